// File: doc/BRIEF.md
# Programmable Synthesizer Divider and Phase Detector

This block holds the digital part of a frequency synthesizer loop. Two programmable dividers sit in one system clock domain. A reference divider counts strobes on `ref_ce` and divides by 12 or 13. A main (feedback) divider counts strobes on `fb_ce` and divides by 2304 plus an 8-bit code. At the end of each period, each divider emits a one-cycle pulse. That pulse is the leading edge seen by a tri-state phase-frequency detector.

The detector drives `pd_up` when the reference pulse leads and `pd_dn` when the feedback pulse leads. Each output stays high for as many cycles as separate the two pulses. The pulse that arrives second ends the output, and coincident pulses produce nothing. A loop-enable input opens the loop by holding both detector outputs low, while both dividers keep counting.

A new ratio written to either divider is picked up only when that divider reaches its terminal count. A period that is already in progress is therefore never cut short or stretched.

Top module: `synth_div_pfd`

## Requirements
- R1: `fb_div_o` pulses high for one cycle once every 2304 + n `fb_ce` strobes. Here n is `n_code` read as an unsigned 8-bit number with bit 7 as the MSB, so the ratio runs from 2304 to 2559.
- R2: `ref_div_o` pulses high for one cycle once every R `ref_ce` strobes. R is 13 when `ref_sel` is 2'b01 and 12 for 2'b00, 2'b10 and 2'b11. Cycles without a strobe are not counted.
- R3: When the reference pulse comes d cycles before the feedback pulse, `pd_up` is high for exactly d cycles and `pd_dn` stays low. The mirror case gives `pd_dn` d cycles. Pulses in the same cycle leave both outputs low.
- R4: `pd_up` rises only in the cycle after a `ref_div_o` pulse, and `pd_dn` rises only in the cycle after a `fb_div_o` pulse.
- R5: `pd_up` and `pd_dn` are never high in the same cycle.
- R6: While `loop_en` is low, both detector outputs are low from the next cycle onward, and both dividers keep producing their pulses.
- R7: A change of `n_code` or `ref_sel` during a period does not alter that period. The new ratio applies from the period that follows the next terminal count.
- R8: While `rst` is high, all outputs are low and the ratios are sampled. After release, the first divider pulse appears after a full period counted from zero.
- R9: A detector output that is high falls only in the cycle after the opposite divider pulse, or in the cycle after `loop_en` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_ce | input | 1 | Reference clock strobe, one cycle per reference period |
| fb_ce | input | 1 | Feedback clock strobe, one cycle per oscillator period |
| ref_sel | input | 2 | Reference ratio select (01: 13, others: 12) |
| n_code | input | 8 | Main divider offset code n |
| loop_en | input | 1 | High closes the loop; low holds both detector outputs low |
| ref_div_o | output | 1 | Divided reference pulse |
| fb_div_o | output | 1 | Divided feedback pulse |
| pd_up | output | 1 | Detector source output (reference leads) |
| pd_dn | output | 1 | Detector sink output (feedback leads) |

## Verification
A corrupted counter or a misloaded ratio shows up as a divider pulse at the wrong cycle. The error is visible at the first terminal count after it occurs, which is at most one period of 2559 strobes later. A detector flop stuck high makes that output outlast the opposite divider pulse, or overlap the other output, within one compare period. The bench therefore measures the cycle of every pulse from reset, and counts the high cycles of each detector output against the gap it programmed between the two strobe trains.

// File: rtl/synth_pkg.sv
package synth_pkg;

  typedef enum logic [1:0] {
    REFSEL_DIV12 = 2'b00,
    REFSEL_DIV13 = 2'b01,
    REFSEL_ALT2  = 2'b10,
    REFSEL_ALT3  = 2'b11
  } ref_sel_e;

endpackage

// File: rtl/synth_div_counter.sv
module synth_div_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic [CNT_W-1:0] ratio,
  output logic             tc_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ratio_q;
  logic             at_end;

  assign at_end = (cnt_q == ratio_q - CNT_W'(1));

  // The ratio is taken only at terminal count, so a running period keeps its length
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      ratio_q <= ratio;
      tc_o    <= 1'b0;
    end else begin
      tc_o <= 1'b0;
      if (ce) begin
        if (at_end) begin
          cnt_q   <= '0;
          ratio_q <= ratio;
          tc_o    <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/synth_pfd_core.sv
module synth_pfd_core (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ref_p,
  input  logic fb_p,
  output logic up_o,
  output logic dn_o
);

  logic up_n;
  logic dn_n;
  logic both;

  always_comb begin
    up_n = up_o | ref_p;
    dn_n = dn_o | fb_p;
    both = up_n & dn_n;
  end

  // When both would be set, both are cleared, so the second edge ends the pulse
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else if (both) begin
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else begin
      up_o <= up_n;
      dn_o <= dn_n;
    end
  end

endmodule

// File: rtl/synth_div_pfd.sv
module synth_div_pfd #(
  parameter int N_W       = 8,
  parameter int MAIN_BASE = 2304,
  parameter int REF_LO    = 12,
  parameter int REF_HI    = 13
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ref_ce,
  input  logic           fb_ce,
  input  logic [1:0]     ref_sel,
  input  logic [N_W-1:0] n_code,
  input  logic           loop_en,
  output logic           ref_div_o,
  output logic           fb_div_o,
  output logic           pd_up,
  output logic           pd_dn
);
  import synth_pkg::*;

  localparam int MAIN_W = $clog2(MAIN_BASE + (1 << N_W));
  localparam int REF_W  = $clog2(REF_HI + 1);

  logic [MAIN_W-1:0] main_ratio;
  logic [REF_W-1:0]  ref_ratio;

  assign main_ratio = MAIN_W'(MAIN_BASE) + MAIN_W'(n_code);
  assign ref_ratio  = (ref_sel_e'(ref_sel) == REFSEL_DIV13) ? REF_W'(REF_HI) : REF_W'(REF_LO);

  synth_div_counter #(.CNT_W(REF_W)) ref_div_i (
    .clk   (clk),
    .rst   (rst),
    .ce    (ref_ce),
    .ratio (ref_ratio),
    .tc_o  (ref_div_o)
  );

  synth_div_counter #(.CNT_W(MAIN_W)) fb_div_i (
    .clk   (clk),
    .rst   (rst),
    .ce    (fb_ce),
    .ratio (main_ratio),
    .tc_o  (fb_div_o)
  );

  synth_pfd_core pfd_i (
    .clk   (clk),
    .rst   (rst),
    .en    (loop_en),
    .ref_p (ref_div_o),
    .fb_p  (fb_div_o),
    .up_o  (pd_up),
    .dn_o  (pd_dn)
  );

endmodule

// File: rtl/synth_div_pfd_chk.sv
module synth_div_pfd_chk (
  input logic clk,
  input logic rst,
  input logic loop_en,
  input logic ref_div_o,
  input logic fb_div_o,
  input logic pd_up,
  input logic pd_dn
);

  AST_UPDN_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pd_up && pd_dn)); // R5

  AST_OPEN_LOOP: assert property (@(posedge clk) disable iff (rst)
    !loop_en |=> (!pd_up && !pd_dn)); // R6

  AST_UP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_up) |-> $past(ref_div_o)); // R4

  AST_DN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_dn) |-> $past(fb_div_o)); // R4

  AST_UP_END: assert property (@(posedge clk) disable iff (rst)
    $fell(pd_up) |-> ($past(fb_div_o) || !$past(loop_en))); // R9

  AST_DN_END: assert property (@(posedge clk) disable iff (rst)
    $fell(pd_dn) |-> ($past(ref_div_o) || !$past(loop_en))); // R9

  AST_FB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fb_div_o |=> !fb_div_o); // R1

  AST_REF_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ref_div_o |=> !ref_div_o); // R2

endmodule

bind synth_div_pfd synth_div_pfd_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .loop_en   (loop_en),
  .ref_div_o (ref_div_o),
  .fb_div_o  (fb_div_o),
  .pd_up     (pd_up),
  .pd_dn     (pd_dn)
);

// File: tb/synth_div_pfd_tb_top.sv
module synth_div_pfd_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_ce = 1'b0;
  logic       fb_ce = 1'b0;
  logic [1:0] ref_sel = 2'b00;
  logic [7:0] n_code = 8'd0;
  logic       loop_en = 1'b1;
  logic       ref_div_o, fb_div_o, pd_up, pd_dn;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ref_every = 1, ref_start = 0, fb_every = 1, fb_start = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  synth_div_pfd dut_i (
    .clk(clk), .rst(rst), .ref_ce(ref_ce), .fb_ce(fb_ce),
    .ref_sel(ref_sel), .n_code(n_code), .loop_en(loop_en),
    .ref_div_o(ref_div_o), .fb_div_o(fb_div_o), .pd_up(pd_up), .pd_dn(pd_dn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Strobe values for the next rising edge, derived from cyc
  task automatic set_ce();
    ref_ce = (cyc >= ref_start) && (((cyc - ref_start) % ref_every) == ref_every - 1);
    fb_ce  = (cyc >= fb_start)  && (((cyc - fb_start)  % fb_every)  == fb_every - 1);
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    set_ce();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ref_ce = 1'b0; fb_ce = 1'b0;
    repeat (3) @(negedge clk);
    // R8: outputs low in reset
    chk({ref_div_o, fb_div_o, pd_up, pd_dn} == 4'b0, "R8 reset outputs",
        int'({ref_div_o, fb_div_o, pd_up, pd_dn}), 0);
    rst = 1'b0;
    cyc = 0;
    set_ce();
  endtask

  task automatic wait_ref(input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      tick();
      if (ref_div_o) begin at = cyc; break; end
    end
  endtask

  task automatic wait_fb(input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      tick();
      if (fb_div_o) begin at = cyc; break; end
    end
  endtask

  // R2 / R8: first pulse at a full period, then the steady interval
  task automatic t_ref_ratio(input logic [1:0] sel, input int every, input int exp_div);
    int a, b;
    ref_sel = sel; ref_every = every; ref_start = 0; fb_every = 1; fb_start = 1000000;
    do_reset();
    wait_ref(200, a);
    chk(a == exp_div * every, "R2 R8 first ref pulse", a, exp_div * every);
    wait_ref(200, b);
    chk(b - a == exp_div * every, "R2 ref interval", b - a, exp_div * every);
  endtask

  // R1: main ratio 2304 + n
  task automatic t_main_ratio(input logic [7:0] n, input bit two);
    int a, b;
    n_code = n; ref_every = 1; ref_start = 1000000; fb_every = 1; fb_start = 0;
    do_reset();
    wait_fb(3000, a);
    chk(a == 2304 + int'(n), "R1 first fb pulse", a, 2304 + int'(n));
    if (two) begin
      wait_fb(3000, b);
      chk(b - a == 2304 + int'(n), "R1 fb interval", b - a, 2304 + int'(n));
    end
  endtask

  // R7: ratio change mid period
  task automatic t_reload();
    int a, b, c;
    n_code = 8'd0; ref_every = 1; ref_start = 1000000; fb_every = 1; fb_start = 0;
    do_reset();
    wait_fb(3000, a);
    repeat (100) tick();
    n_code = 8'd10;
    wait_fb(3000, b);
    chk(b - a == 2304, "R7 running period kept", b - a, 2304);
    wait_fb(3000, c);
    chk(c - b == 2314, "R7 new ratio applied", c - b, 2314);
    // R7: reference select changed mid period
    ref_sel = 2'b00; ref_every = 1; ref_start = 0; fb_start = 1000000;
    do_reset();
    repeat (5) tick();
    ref_sel = 2'b01;
    wait_ref(100, a);
    chk(a == 12, "R7 ref period kept", a, 12);
    wait_ref(100, b);
    chk(b - a == 13, "R7 ref new ratio", b - a, 13);
  endtask

  // R3 R4 R5 R6: detector against programmed phase gap
  task automatic t_phase(input int s_r, input int s_f, input bit en,
                         input int exp_up, input int exp_dn, input string tag);
    int up_n = 0, dn_n = 0, both_n = 0, nref = 0, nfb = 0;
    int t_ref = -1, t_fb = -1, t_up = -1, t_dn = -1;
    int stop;
    n_code = 8'd0; ref_sel = 2'b00; loop_en = en;
    ref_every = 192; ref_start = s_r; fb_every = 1; fb_start = s_f;
    do_reset();
    stop = 2304 + ((s_r > s_f) ? s_r : s_f) + 20;
    while (cyc < stop) begin
      tick();
      if (ref_div_o) begin nref++; t_ref = cyc; end
      if (fb_div_o)  begin nfb++;  t_fb = cyc; end
      if (pd_up) begin up_n++; if (t_up < 0) t_up = cyc; end
      if (pd_dn) begin dn_n++; if (t_dn < 0) t_dn = cyc; end
      if (pd_up && pd_dn) both_n++;
    end
    chk(up_n == exp_up, {"R3 up width ", tag}, up_n, exp_up);
    chk(dn_n == exp_dn, {"R3 dn width ", tag}, dn_n, exp_dn);
    chk(both_n == 0, {"R5 overlap ", tag}, both_n, 0);
    chk(nref == 1 && nfb == 1, {"R6 dividers running ", tag}, nref * 10 + nfb, 11);
    if (exp_up > 0) chk(t_up == t_ref + 1, {"R4 up latency ", tag}, t_up, t_ref + 1);
    if (exp_dn > 0) chk(t_dn == t_fb + 1, {"R4 dn latency ", tag}, t_dn, t_fb + 1);
    loop_en = 1'b1;
  endtask

  initial begin
    t_ref_ratio(2'b00, 1, 12);
    t_ref_ratio(2'b01, 1, 13);
    t_ref_ratio(2'b10, 1, 12);
    t_ref_ratio(2'b11, 1, 12);
    t_ref_ratio(2'b01, 3, 13);
    t_main_ratio(8'd0,   1'b1);
    t_main_ratio(8'd255, 1'b1);
    t_main_ratio(8'd98,  1'b0);
    t_reload();
    t_phase(0, 7, 1'b1, 7, 0, "ref leads");
    t_phase(5, 0, 1'b1, 0, 5, "fb leads");
    t_phase(4, 4, 1'b1, 0, 0, "aligned");
    t_phase(0, 1, 1'b1, 1, 0, "one cycle");
    t_phase(0, 9, 1'b0, 0, 0, "R6 loop open");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule